// File: doc/BRIEF.md
# Contiguous Transfer Request Coalescing Queue

This block sits in front of a byte-serial output engine. It accepts write requests, each a start address and a byte count. It keeps at most two descriptors: one active transfer that the engine is draining, and one pending transfer waiting behind it. A request whose start address continues exactly where a descriptor ends is folded into that descriptor. No new slot is used. This lets a stream of adjacent small writes run as one long transfer without gaps.

A non-adjacent request takes the pending slot when that slot is empty. When the slot is full, the block holds off the requester. Each cycle the engine either takes the next byte address or does not. When the active descriptor has no bytes left, the pending descriptor moves into its place. A query port answers, in the same cycle, whether a given address has not yet been handed to the engine.

A requester that is held off for too long triggers an abort. The abort drops both descriptors, discards the held request and reports the event.

Top module: `coal_queue`

## Requirements
- R1: After reset, busy_o, out_valid_o, query_pending_o and timeout_o are all 0.
- R2: With no active descriptor, an offered request is accepted in the same cycle (req_ready_o=1). From the next cycle it is the active transfer, with out_addr_o equal to its start address.
- R3: Suppose a request is offered while the pending slot is empty, and its address equals the active start plus the active total. Then it is accepted and its count is added to the active total, so its bytes follow the active bytes with no gap.
- R4: Suppose a request is offered while the pending slot is occupied, and its address equals the pending start plus the pending count. Then it is accepted and its count is added to the pending descriptor.
- R5: A request that merges with neither descriptor, offered while the active slot is busy and the pending slot is empty, is accepted and becomes the pending descriptor.
- R6: A request that merges with neither descriptor, offered while the pending slot is occupied, is held off with req_ready_o=0. It is checked again every cycle and accepted once a slot or a merge becomes possible.
- R7: In a cycle with out_valid_o=1 and consume_i=1, the engine takes the byte at out_addr_o, and out_addr_o then moves to the next address. Bytes are delivered in the order of acceptance, with merged bytes directly after the bytes they extend.
- R8: After the last byte of the active descriptor is taken, the pending descriptor becomes active, with its byte count restarted from zero. If no pending descriptor exists, busy_o falls.
- R9: query_pending_o is 1 exactly when query_addr_i lies in the untaken part of the active descriptor or anywhere inside the pending descriptor.
- R10: While busy_o=0, query_pending_o is 0 for every address.
- R11: A request held off for TIMEOUT_CYC consecutive cycles is discarded in its TIMEOUT_CYC-th stalled cycle. In that cycle req_ready_o=1 and timeout_o=1.
- R12: After a timeout, both descriptors are gone: busy_o=0 and no address queries as pending. The next request starts a fresh active transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_addr_i | input | AW | Request start address |
| req_len_i | input | CW | Request byte count |
| req_ready_o | output | 1 | Request accepted (or discarded on timeout) this cycle |
| timeout_o | output | 1 | Held request timed out; descriptors dropped |
| consume_i | input | 1 | Engine takes the byte at out_addr_o |
| out_valid_o | output | 1 | A byte is available to the engine |
| out_addr_o | output | AW | Address of the next byte to send |
| busy_o | output | 1 | An active descriptor exists |
| query_addr_i | input | AW | Address to look up |
| query_pending_o | output | 1 | Queried address not yet sent |

## Verification
The main stimulus is a fixed sequence of requests with the engine frozen. The sequence contains a request that continues the active transfer and a gapped request that takes the free slot. It also contains a request that continues that pending slot, and a gapped request that must stall. The effect of each request is then confirmed through the byte order the engine receives and through stall counts at the requester. Queries are made at the ends of each descriptor's range, one address inside and one just past. These show the exclusive upper bound and the consumed prefix. A second pattern leaves a stall in place until the timeout expires. It then confirms that the abort is exact to the cycle and that a fresh request starts cleanly afterwards.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [2:0] {
    DEC_NONE,
    DEC_START,
    DEC_JOIN_ACT,
    DEC_JOIN_PEND,
    DEC_FILL_PEND,
    DEC_STALL
  } coal_dec_e;
endpackage

// File: rtl/coal_merge_dec.sv
module coal_merge_dec
  import coal_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          act_v_i,
  input  logic [AW-1:0] act_end_i,
  input  logic          pend_v_i,
  input  logic [AW-1:0] pend_end_i,
  output coal_dec_e     dec_o
);
  always_comb begin
    if (!req_valid_i)                           dec_o = DEC_NONE;
    else if (!act_v_i)                          dec_o = DEC_START;
    else if (!pend_v_i && req_addr_i == act_end_i) dec_o = DEC_JOIN_ACT;
    else if (pend_v_i && req_addr_i == pend_end_i)  dec_o = DEC_JOIN_PEND;
    else if (!pend_v_i)                         dec_o = DEC_FILL_PEND;
    else                                        dec_o = DEC_STALL;
  end
endmodule

// File: rtl/coal_query.sv
module coal_query #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic [AW-1:0] q_addr_i,
  input  logic          act_v_i,
  input  logic [AW-1:0] act_base_i,
  input  logic [CW-1:0] act_cons_i,
  input  logic [CW-1:0] act_tot_i,
  input  logic          pend_v_i,
  input  logic [AW-1:0] pend_base_i,
  input  logic [CW-1:0] pend_len_i,
  output logic          hit_o
);
  localparam int XW = AW + 1;
  logic [XW-1:0] q, a_lo, a_hi, p_lo, p_hi;

  // one extra bit so a range ending at the top of the space does not wrap
  always_comb begin
    q     = {1'b0, q_addr_i};
    a_lo  = {1'b0, act_base_i} + XW'(act_cons_i);
    a_hi  = {1'b0, act_base_i} + XW'(act_tot_i);
    p_lo  = {1'b0, pend_base_i};
    p_hi  = {1'b0, pend_base_i} + XW'(pend_len_i);
    hit_o = (act_v_i && q >= a_lo && q < a_hi) ||
            (pend_v_i && q >= p_lo && q < p_hi);
  end
endmodule

// File: rtl/coal_stall_timer.sv
module coal_stall_timer #(
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_i,
  output logic expire_o
);
  localparam int CNTW = $clog2(TIMEOUT_CYC + 1);
  logic [CNTW-1:0] cnt_q;

  assign expire_o = stall_i && (cnt_q == CNTW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!stall_i || expire_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNTW'(TIMEOUT_CYC));
  p_expire_after_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TIMEOUT_CYC > 1 && expire_o) |-> $past(stall_i));
endmodule

// File: rtl/coal_queue.sv
module coal_queue
  import coal_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CW          = 16,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [CW-1:0] req_len_i,
  output logic          req_ready_o,
  output logic          timeout_o,
  input  logic          consume_i,
  output logic          out_valid_o,
  output logic [AW-1:0] out_addr_o,
  output logic          busy_o,
  input  logic [AW-1:0] query_addr_i,
  output logic          query_pending_o
);
  logic          act_v, pend_v;
  logic [AW-1:0] act_base, pend_base;
  logic [CW-1:0] act_tot, act_cons, pend_len;

  logic [AW-1:0] act_end, pend_end;
  coal_dec_e     dec;
  logic          abort, take;
  logic [CW-1:0] tot_m, pl_m;
  logic [AW-1:0] pb_m;
  logic          pv_m, done;

  assign act_end  = act_base + AW'(act_tot);
  assign pend_end = pend_base + AW'(pend_len);

  coal_merge_dec #(.AW(AW)) i_dec (
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .act_v_i     (act_v),
    .act_end_i   (act_end),
    .pend_v_i    (pend_v),
    .pend_end_i  (pend_end),
    .dec_o       (dec)
  );

  coal_stall_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stall_i  (dec == DEC_STALL),
    .expire_o (abort)
  );

  coal_query #(.AW(AW), .CW(CW)) i_query (
    .q_addr_i    (query_addr_i),
    .act_v_i     (act_v),
    .act_base_i  (act_base),
    .act_cons_i  (act_cons),
    .act_tot_i   (act_tot),
    .pend_v_i    (pend_v),
    .pend_base_i (pend_base),
    .pend_len_i  (pend_len),
    .hit_o       (query_pending_o)
  );

  assign req_ready_o = (dec != DEC_NONE && dec != DEC_STALL) || abort;
  assign timeout_o   = abort;
  assign busy_o      = act_v;
  assign out_valid_o = act_v && (act_cons != act_tot);
  assign out_addr_o  = act_base + AW'(act_cons);
  assign take        = out_valid_o && consume_i;

  // merged view of both descriptors for this cycle
  always_comb begin
    tot_m = act_tot;
    pv_m  = pend_v;
    pb_m  = pend_base;
    pl_m  = pend_len;
    case (dec)
      DEC_JOIN_ACT:  tot_m = act_tot + req_len_i;
      DEC_JOIN_PEND: pl_m  = pend_len + req_len_i;
      DEC_FILL_PEND: begin
        pv_m = 1'b1;
        pb_m = req_addr_i;
        pl_m = req_len_i;
      end
      default: ;
    endcase
    done = act_v && (act_cons == tot_m);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_v     <= 1'b0;
      act_base  <= '0;
      act_tot   <= '0;
      act_cons  <= '0;
      pend_v    <= 1'b0;
      pend_base <= '0;
      pend_len  <= '0;
    end else if (abort) begin
      act_v  <= 1'b0;
      pend_v <= 1'b0;
    end else if (dec == DEC_START) begin
      act_v    <= 1'b1;
      act_base <= req_addr_i;
      act_tot  <= req_len_i;
      act_cons <= '0;
    end else if (act_v) begin
      if (done) begin
        if (pv_m) begin
          act_base <= pb_m;
          act_tot  <= pl_m;
          act_cons <= '0;
          pend_v   <= 1'b0;
        end else begin
          act_v <= 1'b0;
        end
      end else begin
        act_tot   <= tot_m;
        act_cons  <= act_cons + {{(CW-1){1'b0}}, take};
        pend_v    <= pv_m;
        pend_base <= pb_m;
        pend_len  <= pl_m;
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !busy_o);
  p_start_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o && out_addr_o == $past(req_addr_i));
  p_stall_needs_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |-> pend_v);
  p_pend_needs_act_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_v |-> act_v);
  p_cons_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_v |-> act_cons <= act_tot);
  p_advance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !abort) |=> (!out_valid_o || out_addr_o == $past(out_addr_o) + 1'b1));
  p_promote_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_v && act_cons == act_tot && pend_v && !abort)
      |=> busy_o && out_addr_o == $past(pend_base));
  p_idle_query_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !query_pending_o);
  p_timeout_flush_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !busy_o);
endmodule

// File: tb/test_coal_queue.sv
module test_coal_queue;
  localparam int CLK_P = 10;
  localparam int AW    = 16;
  localparam int CW    = 8;
  localparam int TO    = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [CW-1:0] req_len_i = '0;
  logic          req_ready_o, timeout_o;
  logic          consume_i = 1'b0;
  logic          out_valid_o, busy_o, query_pending_o;
  logic [AW-1:0] out_addr_o;
  logic [AW-1:0] query_addr_i = '0;

  int checks = 0, fails = 0, popped = 0;
  bit cons_en = 1'b0, done_flag = 1'b0;
  logic [AW-1:0] exp_q[$];

  always #(CLK_P/2) clk_i = ~clk_i;

  coal_queue #(.AW(AW), .CW(CW), .TIMEOUT_CYC(TO)) i_coal_queue (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_len_i, .req_ready_o,
    .timeout_o, .consume_i, .out_valid_o, .out_addr_o, .busy_o,
    .query_addr_i, .query_pending_o
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor: engine takes one byte per cycle when enabled
  initial forever begin
    @(negedge clk_i);
    if (cons_en && out_valid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected byte", int'(out_addr_o), 0);
      else begin
        logic [AW-1:0] e;
        e = exp_q.pop_front();
        chk(out_addr_o == e, "R7", "byte order", int'(out_addr_o), int'(e));
      end
      popped++;
      consume_i = 1'b1;
    end else consume_i = 1'b0;
  end

  task automatic send(input logic [AW-1:0] a, input int n,
                      output int stalls, output bit to);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    req_len_i   = CW'(n);
    stalls = 0;
    to = 1'b0;
    forever begin
      #(CLK_P/4);
      if (req_ready_o) begin
        to = timeout_o;
        if (!to) for (int i = 0; i < n; i++) exp_q.push_back(a + AW'(i));
        @(negedge clk_i);
        req_valid_i = 1'b0;
        break;
      end
      stalls++;
      @(negedge clk_i);
    end
  endtask

  task automatic query(input logic [AW-1:0] a, input bit exp, input string rq);
    query_addr_i = a;
    #1;
    chk(query_pending_o == exp, rq, "query", int'(query_pending_o), int'(exp));
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (!busy_o && exp_q.size() == 0) break;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int st;
    bit to;
    #(CLK_P * 3 + 2);
    chk(busy_o == 0 && out_valid_o == 0, "R1", "idle after reset", int'(busy_o), 0);
    chk(query_pending_o == 0 && timeout_o == 0, "R1", "flags after reset",
        int'(query_pending_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    send(16'h0100, 4, st, to);
    chk(st == 0, "R2", "start stalls", st, 0);
    chk(out_valid_o && out_addr_o == 16'h0100, "R2", "start addr", int'(out_addr_o), 'h100);
    send(16'h0104, 3, st, to);
    chk(st == 0, "R3", "join active stalls", st, 0);
    query(16'h0106, 1'b1, "R9");
    query(16'h0107, 1'b0, "R9");
    send(16'h0200, 2, st, to);
    chk(st == 0, "R5", "fill pending stalls", st, 0);
    query(16'h0201, 1'b1, "R9");
    send(16'h0202, 2, st, to);
    chk(st == 0, "R4", "join pending stalls", st, 0);
    query(16'h0203, 1'b1, "R9");
    query(16'h0204, 1'b0, "R9");

    fork
      begin repeat (6) @(negedge clk_i); cons_en = 1'b1; end
    join_none
    send(16'h0300, 1, st, to);
    chk(st >= 6 && !to, "R6", "held then accepted", st, 6);
    query(16'h0100, 1'b0, "R9");
    drain();
    chk(popped == 12, "R8", "bytes delivered", popped, 12);
    chk(!busy_o, "R8", "idle after drain", int'(busy_o), 0);
    query(16'h0300, 1'b0, "R10");

    cons_en = 1'b0;
    send(16'h0400, 2, st, to);
    send(16'h0500, 1, st, to);
    send(16'h0600, 1, st, to);
    chk(to == 1'b1, "R11", "timeout flag", int'(to), 1);
    chk(st == TO - 1, "R11", "stall cycles", st, TO - 1);
    exp_q.delete();
    chk(!busy_o, "R12", "flushed", int'(busy_o), 0);
    query(16'h0400, 1'b0, "R12");
    query(16'h0500, 1'b0, "R12");
    send(16'h0700, 2, st, to);
    chk(st == 0 && out_addr_o == 16'h0700, "R12", "fresh start", int'(out_addr_o), 'h700);
    cons_en = 1'b1;
    drain();
    chk(popped == 14, "R7", "bytes after restart", popped, 14);
    summary();
  end
endmodule